// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the 8-bit arithmetic and logic unit of a small accumulator-based processor. Each cycle it takes an operation code, one operand byte, the held accumulator and the held carry flag. From these it forms a result byte, a write-enable for the result's destination, and new values for four condition flags: zero (Z), subtract (N), half-carry (H) and carry (C). Every operation sets the flags by its own rule. Compare produces flags only. Increment and decrement keep the carry they were given.

A registered wrapper holds the accumulator and the four flags. Both change on a clock edge only when the caller raises a valid strobe. The result byte and its write-enable are combinational, so the register file outside can capture the outcome of an increment or decrement in the same edge.

Increment and decrement work on the operand byte and not on the accumulator. To step the accumulator, the caller presents its value as the operand and writes the result back. Operand fetch and instruction sequencing sit outside this block.

Top module: `acc_alu_unit`

## Requirements
- R1: While reset is asserted, and on the first edges after it, the accumulator and all flags read zero. `flags_o` is packed as Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and bits 3:0 always read zero.
- R2: The accumulator and flags change only on a rising clock edge where `valid_i` is high. With `valid_i` low they hold, whatever `op_i` and `operand_i` carry.
- R3: ADD (code 0) loads acc+operand into the accumulator, and ADC (code 1) loads acc+operand+C. Z is set on a zero byte and N is cleared. H is set on a carry out of bit 3 and C on a carry out of bit 7.
- R4: SUB (code 2) loads acc−operand, and SBC (code 3) loads acc−operand−C, both with 8-bit wraparound. N is set. H is set when the low nibble of acc is below the low nibble of the operand plus the carry-in. C is set when acc is below the operand plus the carry-in.
- R5: AND (code 4) loads acc&operand. Z is set on zero, N and C are cleared, and H is set.
- R6: XOR (code 5) loads acc^operand and OR (code 6) loads acc|operand. Z is set on zero and N, H and C are all cleared.
- R7: Compare (code 7) sets the flags as SUB with no carry-in would. It leaves the accumulator unchanged and holds `res_wr_o` low.
- R8: Increment (code 8) drives `res_o` = operand+1 with wraparound and raises `res_wr_o`. On the edge it leaves the accumulator unchanged, sets Z on zero, clears N, sets H exactly when the operand's low nibble was 0xF, and keeps C.
- R9: Decrement (code 9) drives `res_o` = operand−1 with wraparound and raises `res_wr_o`. On the edge it leaves the accumulator unchanged, sets Z on zero, sets N, sets H exactly when the operand's low nibble was 0x0, and keeps C.
- R10: Codes 10 to 15 are reserved. They hold `res_wr_o` low and leave the accumulator and flags unchanged even when `valid_i` is high.
- R11: `res_o` and `res_wr_o` are combinational in the current accumulator, carry, operand and code. `res_wr_o` is high only when `valid_i` is high and the code is 0 to 6, 8 or 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Operand byte |
| res_o | output | 8 | Combinational result byte |
| res_wr_o | output | 1 | Result should be written to its destination |
| acc_o | output | 8 | Held accumulator |
| flags_o | output | 8 | Held flags: Z, N, H, C in bits 7..4, bits 3:0 zero |

## Verification
In one cycle the carry flag can be both read as the carry-in of ADC or SBC and rewritten by the same edge. The bench provokes this by issuing an overflowing ADD or an underflowing SUB and then ADC or SBC on the very next strobe, with no idle cycle between them. It also issues increment and decrement straight after a carry-setting operation. Each chained result and flag byte is judged against an independent reference that folds in the carry produced one edge earlier, and the result seen at `res_o` before the edge is checked as well.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o,
  output logic              carry_o
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ? ~cin_i : cin_i;
    sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
    res_o = sum[DATA_W-1:0];
    // carry into bit NIB_W recovered from the sum bit
    half_o  = (a_i[NIB_W] ^ b_eff[NIB_W] ^ sum[NIB_W]) ^ sub_i;
    carry_o = sum[DATA_W] ^ sub_i;
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_sel_e        sel_i,
  output logic [DATA_W-1:0] res_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign res_o[i] = (sel_i == LG_AND) ? (a_i[i] & b_i[i]) :
                      (sel_i == LG_OR)  ? (a_i[i] | b_i[i]) :
                                          (a_i[i] ^ b_i[i]);
  end
endmodule

// File: rtl/acc_alu_step.sv
module acc_alu_step #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              dec_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    res_o  = dec_i ? (val_i - ONE) : (val_i + ONE);
    half_o = dec_i ? (val_i[NIB_W-1:0] == '0) : (val_i[NIB_W-1:0] == '1);
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_wr_o,
  output logic              acc_ld_o,
  output logic              flag_ld_o,
  output alu_flags_t        flag_o
);
  alu_op_e           op;
  logic              as_sub, as_cin;
  logic [DATA_W-1:0] as_res, lg_res, st_res;
  logic              as_h, as_c, st_h;
  logic_sel_e        lg_sel;
  logic              known, writes_acc, writes_dst;
  logic [DATA_W-1:0] r;
  logic              n, h, c;

  assign op = alu_op_e'(op_i);

  always_comb begin
    as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? carry_i : 1'b0;
    case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_XOR;
    endcase
  end

  acc_alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_addsub (
    .a_i(acc_i), .b_i(operand_i), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .half_o(as_h), .carry_o(as_c)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) i_logic (
    .a_i(acc_i), .b_i(operand_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  acc_alu_step #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_step (
    .val_i(operand_i), .dec_i(op == OP_DEC), .res_o(st_res), .half_o(st_h)
  );

  always_comb begin
    r          = '0;
    n          = 1'b0;
    h          = 1'b0;
    c          = carry_i;
    known      = 1'b1;
    writes_acc = 1'b0;
    writes_dst = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        r          = as_res;
        n          = as_sub;
        h          = as_h;
        c          = as_c;
        writes_acc = (op != OP_CMP);
        writes_dst = (op != OP_CMP);
      end
      OP_AND, OP_OR, OP_XOR: begin
        r          = lg_res;
        h          = (op == OP_AND);
        c          = 1'b0;
        writes_acc = 1'b1;
      end
      OP_INC, OP_DEC: begin
        r = st_res;
        n = (op == OP_DEC);
        h = st_h;
      end
      default: begin
        known      = 1'b0;
        writes_dst = 1'b0;
      end
    endcase
    res_o     = r;
    res_wr_o  = valid_i & writes_dst;
    acc_ld_o  = valid_i & writes_acc;
    flag_ld_o = valid_i & known;
    flag_o    = '{z: (r == '0), n: n, h: h, c: c};
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_wr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [7:0]        flags_o
);
  logic              rst_meta, rst_sync;
  logic [DATA_W-1:0] acc_q, acc_d;
  alu_flags_t        flag_q, flag_d, flag_new;
  logic              acc_ld, flag_ld;

  // reset asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  acc_alu_core #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_core (
    .valid_i(valid_i), .op_i(op_i), .acc_i(acc_q), .operand_i(operand_i),
    .carry_i(flag_q.c), .res_o(res_o), .res_wr_o(res_wr_o),
    .acc_ld_o(acc_ld), .flag_ld_o(flag_ld), .flag_o(flag_new)
  );

  always_comb begin
    acc_d  = acc_q;
    flag_d = flag_q;
    if (acc_ld)  acc_d  = res_o;
    if (flag_ld) flag_d = flag_new;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      acc_q  <= '0;
      flag_q <= '0;
    end else begin
      acc_q  <= acc_d;
      flag_q <= flag_d;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = {flag_q, 4'b0000};
endmodule

// File: rtl/acc_alu_unit_chk.sv
module acc_alu_unit_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              res_wr_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [7:0]        flags_o
);
  // R1
  flag_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    flags_o[3:0] == 4'h0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !valid_i |=> ($stable(acc_o) && $stable(flags_o)));

  // R4
  sub_sets_n_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (valid_i && (op_i == OP_SUB || op_i == OP_SBC || op_i == OP_CMP || op_i == OP_DEC))
    |=> flags_o[6]);

  // R6
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (valid_i && (op_i == OP_XOR || op_i == OP_OR)) |=> (flags_o[6:4] == 3'b000));

  // R7
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (valid_i && op_i == OP_CMP) |=> $stable(acc_o));

  // R8
  step_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (valid_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[4] == $past(flags_o[4])));

  // R10
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (valid_i && op_i >= 4'd10) |=> ($stable(acc_o) && $stable(flags_o)));

  // R11
  no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (!valid_i || op_i >= 4'd10 || op_i == OP_CMP) |-> !res_wr_o);
endmodule

bind acc_alu_unit acc_alu_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_sync(rst_sync), .valid_i(valid_i), .op_i(op_i),
  .res_wr_o(res_wr_o), .acc_o(acc_o), .flags_o(flags_o)
);

// File: tb/test_acc_alu_unit.sv
module test_acc_alu_unit;
  logic       clk;
  logic       rst_n;
  logic       valid_i;
  logic [3:0] op_i;
  logic [7:0] operand_i;
  logic [7:0] res_o;
  logic       res_wr_o;
  logic [7:0] acc_o;
  logic [7:0] flags_o;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  // shadow state built from the requirements
  logic [7:0] sh_acc;
  logic [7:0] sh_f;

  acc_alu_unit i_acc_alu_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .res_o(res_o), .res_wr_o(res_wr_o),
    .acc_o(acc_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: act=%02h exp=%02h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                input logic [7:0] f, output logic [7:0] r, output logic [7:0] nf,
                                output logic wa, output logic wd, output logic fl);
    int ia, ib, k, s;
    logic n, h, c;
    ia = int'(a); ib = int'(b);
    n = 1'b0; h = 1'b0; c = f[4]; r = 8'h00; wa = 1'b0; wd = 1'b1; fl = 1'b1; k = 0;
    case (op)
      4'd0, 4'd1: begin
        k = (op == 4'd1) ? int'(f[4]) : 0;
        s = ia + ib + k; r = 8'(s);
        h = ((ia & 15) + (ib & 15) + k) > 15; c = s > 255; wa = 1'b1;
      end
      4'd2, 4'd3, 4'd7: begin
        k = (op == 4'd3) ? int'(f[4]) : 0;
        s = ia - ib - k; r = 8'(s); n = 1'b1;
        h = (ia & 15) < ((ib & 15) + k); c = ia < (ib + k);
        wa = (op != 4'd7); wd = wa;
      end
      4'd4: begin r = a & b; h = 1'b1; c = 1'b0; wa = 1'b1; end
      4'd5: begin r = a ^ b; c = 1'b0; wa = 1'b1; end
      4'd6: begin r = a | b; c = 1'b0; wa = 1'b1; end
      4'd8: begin r = 8'(ib + 1); h = (ib & 15) == 15; end
      4'd9: begin r = 8'(ib - 1); n = 1'b1; h = (ib & 15) == 0; end
      default: begin wd = 1'b0; fl = 1'b0; end
    endcase
    nf = fl ? {(r == 8'h00), n, h, c, 4'b0000} : f;
  endfunction

  // one strobed operation, checked before and after the edge
  task automatic do_op(input logic [3:0] op, input logic [7:0] b, input string req);
    logic [7:0] r, nf;
    logic wa, wd, fl;
    @(negedge clk);
    op_i = op; operand_i = b; valid_i = 1'b1;
    #1;
    model(op, sh_acc, b, sh_f, r, nf, wa, wd, fl);
    if (fl) check(req, "res_o", res_o, r);
    check(req, "res_wr_o", {7'b0, res_wr_o}, {7'b0, wd});
    @(negedge clk);
    valid_i = 1'b0;
    if (wa) sh_acc = r;
    sh_f = nf;
    check(req, "acc_o", acc_o, sh_acc);
    check(req, "flags_o", flags_o, sh_f);
  endtask

  task automatic set_acc(input logic [7:0] v);
    do_op(4'd4, 8'h00, "R5");
    do_op(4'd6, v, "R6");
  endtask

  task automatic t_reset;
    rst_n = 1'b0; valid_i = 1'b0; op_i = 4'd0; operand_i = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", "acc_o in reset", acc_o, 8'h00);
    check("R1", "flags_o in reset", flags_o, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "acc_o after reset", acc_o, 8'h00);
    check("R1", "flags_o after reset", flags_o, 8'h00);
    sh_acc = 8'h00; sh_f = 8'h00;
  endtask

  task automatic t_add;
    set_acc(8'h3A);
    do_op(4'd0, 8'hC6, "R3");
    check("R3", "ADD wrap flags const", flags_o, 8'hB0);
    do_op(4'd1, 8'h0F, "R3");          // carry folded from previous edge
    check("R3", "ADC chained acc const", acc_o, 8'h10);
    check("R3", "ADC chained flags const", flags_o, 8'h20);
    do_op(4'd0, 8'h70, "R3");
    do_op(4'd1, 8'h90, "R3");
  endtask

  task automatic t_sub;
    set_acc(8'h10);
    do_op(4'd2, 8'h01, "R4");
    check("R4", "SUB nibble borrow flags const", flags_o, 8'h60);
    set_acc(8'h00);
    do_op(4'd2, 8'h01, "R4");
    check("R4", "SUB underflow flags const", flags_o, 8'h70);
    do_op(4'd3, 8'hFE, "R4");           // FF - FE - 1
    check("R4", "SBC chained acc const", acc_o, 8'h00);
    check("R4", "SBC chained flags const", flags_o, 8'hC0);
    set_acc(8'h00);
    do_op(4'd2, 8'h01, "R4");
    do_op(4'd3, 8'hFF, "R4");           // FF - FF - 1 borrows
  endtask

  task automatic t_logic;
    set_acc(8'hAA);
    do_op(4'd4, 8'hCC, "R5");
    check("R5", "AND flags const", flags_o, 8'h20);
    do_op(4'd4, 8'h11, "R5");
    check("R5", "AND zero flags const", flags_o, 8'hA0);
    set_acc(8'hF0);
    do_op(4'd5, 8'hF0, "R6");
    check("R6", "XOR self flags const", flags_o, 8'h80);
    do_op(4'd6, 8'h0F, "R6");
    check("R6", "OR acc const", acc_o, 8'h0F);
    do_op(4'd5, 8'hFF, "R6");
  endtask

  task automatic t_cmp;
    set_acc(8'h42);
    do_op(4'd7, 8'h42, "R7");
    check("R7", "CMP equal flags const", flags_o, 8'hC0);
    do_op(4'd7, 8'h50, "R7");
    check("R7", "CMP below flags const", flags_o, 8'h50);
    check("R7", "CMP acc kept", acc_o, 8'h42);
    do_op(4'd7, 8'h0F, "R7");
  endtask

  task automatic t_step;
    set_acc(8'h00);
    do_op(4'd2, 8'h01, "R4");           // carry set
    do_op(4'd8, 8'hFF, "R8");
    check("R8", "INC wrap flags const", flags_o, 8'hB0);
    check("R8", "INC acc kept", acc_o, 8'hFF);
    do_op(4'd9, 8'h10, "R9");
    check("R9", "DEC nibble flags const", flags_o, 8'h70);
    do_op(4'd9, 8'h01, "R9");
    check("R9", "DEC zero flags const", flags_o, 8'hD0);
    do_op(4'd6, 8'h01, "R6");           // carry cleared
    do_op(4'd8, 8'h3E, "R8");
    do_op(4'd9, 8'h00, "R9");
  endtask

  task automatic t_hold;
    set_acc(8'h5A);
    @(negedge clk);
    op_i = 4'd0; operand_i = 8'h55; valid_i = 1'b0;
    #1;
    check("R11", "res_wr_o without strobe", {7'b0, res_wr_o}, 8'h00);
    repeat (3) @(negedge clk);
    check("R2", "acc_o idle", acc_o, sh_acc);
    check("R2", "flags_o idle", flags_o, sh_f);
  endtask

  task automatic t_reserved;
    set_acc(8'h00);
    do_op(4'd2, 8'h01, "R4");
    for (int c = 10; c < 16; c++) begin
      do_op(4'(c), 8'h80, "R10");
    end
  endtask

  task automatic t_sweep;
    logic [7:0] lf;
    lf = 8'h1D;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      do_op(4'(i % 11 == 10 ? 12 : i % 11), lf, "R11");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog: act=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_cmp();
    t_step();
    t_hold();
    t_reserved();
    t_sweep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule